// File: doc/BRIEF.md
# Multi-format pixel to ARGB expander

This block turns one packed pixel per transfer into a uniform 32-bit ARGB word with 8 bits per channel. Each input transfer carries the pixel, a control word that describes how the pixel is packed, and a constant fill colour. The control word holds a 5-bit base format code plus three modifier flags: reverse the byte order, move the alpha field from the top of the pixel to its bottom, and treat an 8-bit alpha as a full 0..255 value rather than a 0..128 value. A fourth flag replaces the pixel with the fill colour.

Narrow components are widened to 8 bits by repeating their most significant bits. Formats without alpha come out opaque. An unknown format code yields opaque black and raises an error flag that travels with that pixel. Input and output both use a valid/ready handshake. A single output register gives one cycle of latency, and the block accepts one pixel per cycle while the consumer keeps up.

Top module: `pixel_argb_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0.
- R2: `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1. A pixel accepted at a clock edge appears on `out_argb` with `out_valid` high right after that edge. Output data stays stable while `out_valid` is high and `out_ready` is low. Back-to-back pixels are accepted every cycle while `out_ready` stays 1.
- R3: For 16-bit formats, the format code sits in `ctrl_word[4:0]`. Code 0x00 has R in [15:11], G in [10:5] and B in [4:0]. Code 0x06 has A in [15], R in [14:10], G in [9:5] and B in [4:0]. Code 0x07 has A, R, G and B in [15:12], [11:8], [7:4] and [3:0]. A 5-bit field v becomes {v, v[4:2]}, a 6-bit field becomes {v, v[5:4]}, and a 4-bit field becomes {v, v}.
- R4: Code 0x01 has R, G and B in [23:16], [15:8] and [7:0]. Code 0x02 uses the same fields and ignores [31:24]. Code 0x04 has A in [23:16] and the code 0x00 layout in [15:0]. Code 0x05 has A, R, G and B in [31:24], [23:16], [15:8] and [7:0]. The output is {A, R, G, B}, with A in [31:24].
- R5: When `ctrl_word[23]` is 1, the bytes of the pixel are reversed before the fields are decoded. The reversal spans 2 bytes for codes 0x00, 0x06 and 0x07, 3 bytes for 0x01 and 0x04, and 4 bytes for 0x02 and 0x05.
- R6: When `ctrl_word[6]` is 1 and the format has alpha, alpha is taken from the low end of the pixel and the colour fields from above it. This is the layout of R3/R4 rotated right by the alpha width within the pixel width, applied after the R5 reversal. For formats without alpha, bit 6 has no effect.
- R7: For codes 0x04 and 0x05, `ctrl_word[5]` = 1 passes the 8-bit alpha through unchanged. With bit 5 = 0, an alpha a of 128 or less becomes 2a - (a==128), and any larger alpha becomes 0xFF.
- R8: A 1-bit alpha maps to 0x00 or 0xFF. Codes 0x00, 0x01 and 0x02 always output alpha 0xFF.
- R9: Codes 0x03 and 0x08..0x1F (with fill off) output 0xFF000000 with `out_fmt_err` = 1. Valid codes output `out_fmt_err` = 0.
- R10: When `ctrl_word[8]` is 1, the output is `fill_argb` and `out_fmt_err` is 0, whatever the pixel and format code.
- R11: Control bits other than [4:0], 5, 6, 8 and 23 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | 32 | Packed pixel, low-aligned |
| ctrl_word | input | 32 | Format code and modifier flags for this pixel |
| fill_argb | input | 32 | Colour used when fill is enabled |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_argb | output | 32 | Expanded {A,R,G,B} |
| out_fmt_err | output | 1 | Pixel had an undefined format code |

## Verification
Every result is due in the cycle right after the edge that accepted its pixel, and it stays there until an edge at which `out_ready` is high. The driver records each expected word at the falling edge where it sees `in_ready` high, which means the next rising edge accepts the pixel. The monitor compares at a falling edge where `out_valid` and `out_ready` are both high, so each word is checked exactly once, in the cycle it leaves. A directed check samples the outputs 1 ns after the accepting edge to pin down the single-cycle latency. A six-pixel burst checks that acceptances land on consecutive cycles, and a pseudo-random stall phase checks that stalled output words are held.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

   typedef enum logic [4:0] {
      FMT_RGB565   = 5'h00,
      FMT_RGB888   = 5'h01,
      FMT_XRGB32   = 5'h02,
      FMT_ARGB8565 = 5'h04,
      FMT_ARGB8888 = 5'h05,
      FMT_ARGB1555 = 5'h06,
      FMT_ARGB4444 = 5'h07
   } pxe_fmt_e;

   localparam int unsigned CTL_FMT_W      = 5;
   localparam int unsigned CTL_ALPHA_FULL = 5;
   localparam int unsigned CTL_ALPHA_LOW  = 6;
   localparam int unsigned CTL_FILL       = 8;
   localparam int unsigned CTL_BIG_END    = 23;

   typedef struct packed {
      logic       known;
      logic [2:0] nbytes;
      logic [3:0] a_bits;
   } pxe_layout_t;

   function automatic pxe_layout_t layout_of(input logic [4:0] code);
      pxe_layout_t l;
      l = '{known: 1'b1, nbytes: 3'd4, a_bits: 4'd0};
      case (code)
         FMT_RGB565:   begin l.nbytes = 3'd2; l.a_bits = 4'd0; end
         FMT_RGB888:   begin l.nbytes = 3'd3; l.a_bits = 4'd0; end
         FMT_XRGB32:   begin l.nbytes = 3'd4; l.a_bits = 4'd0; end
         FMT_ARGB8565: begin l.nbytes = 3'd3; l.a_bits = 4'd8; end
         FMT_ARGB8888: begin l.nbytes = 3'd4; l.a_bits = 4'd8; end
         FMT_ARGB1555: begin l.nbytes = 3'd2; l.a_bits = 4'd1; end
         FMT_ARGB4444: begin l.nbytes = 3'd2; l.a_bits = 4'd4; end
         default:      l.known = 1'b0;
      endcase
      return l;
   endfunction

   function automatic logic [7:0] widen5(input logic [4:0] v);
      return {v, v[4:2]};
   endfunction

   function automatic logic [7:0] widen6(input logic [5:0] v);
      return {v, v[5:4]};
   endfunction

   function automatic logic [7:0] widen4(input logic [3:0] v);
      return {v, v};
   endfunction

endpackage

// File: rtl/pxe_reorder.sv
module pxe_reorder #(
   parameter int unsigned PIX_W       = 32,
   parameter int unsigned LANE_W      = 8,
   parameter bit          SWAP_EN     = 1'b1,
   parameter bit          ALPHA_LO_EN = 1'b1
) (
   input  logic [PIX_W-1:0] pix,
   input  logic [2:0]       nbytes,
   input  logic [3:0]       a_bits,
   input  logic             big_end,
   input  logic             alpha_low,
   output logic [PIX_W-1:0] norm
);
   localparam int unsigned NLANES = PIX_W / LANE_W;

   if ((PIX_W % LANE_W) != 0) begin : g_bad_lane
      $error("pxe_reorder: PIX_W must be a multiple of LANE_W");
   end

   logic [PIX_W-1:0] swapped;
   logic [PIX_W-1:0] width_mask;
   int               nb_i;
   int               w_i;

   always_comb begin
      nb_i = int'(nbytes);
      w_i  = nb_i * int'(LANE_W);
      for (int k = 0; k < int'(PIX_W); k++) begin
         width_mask[k] = (k < w_i);
      end
   end

   // Byte reversal across the pixel's own byte count
   if (SWAP_EN) begin : g_swap
      always_comb begin
         swapped = '0;
         for (int i = 0; i < int'(NLANES); i++) begin
            for (int j = 0; j < int'(NLANES); j++) begin
               if (big_end && (i < nb_i) && (i + j + 1 == nb_i)) begin
                  swapped[i*LANE_W +: LANE_W] = pix[j*LANE_W +: LANE_W];
               end
            end
            if (!big_end && (i < nb_i)) begin
               swapped[i*LANE_W +: LANE_W] = pix[i*LANE_W +: LANE_W];
            end
         end
      end
   end else begin : g_noswap
      logic swap_unused;
      assign swap_unused = big_end;
      assign swapped     = pix & width_mask;
   end

   // Alpha moved from the low end back to the top of the pixel
   if (ALPHA_LO_EN) begin : g_rot
      int a_i;
      always_comb begin
         a_i = int'(a_bits);
         if (alpha_low && (a_i != 0)) begin
            norm = ((swapped >> a_i) | (swapped << (w_i - a_i))) & width_mask;
         end else begin
            norm = swapped;
         end
      end
   end else begin : g_norot
      logic rot_unused;
      assign rot_unused = alpha_low ^ (^a_bits);
      assign norm       = swapped;
   end

endmodule

// File: rtl/pxe_unpack.sv
module pxe_unpack #(
   parameter int unsigned PIX_W     = 32,
   parameter int unsigned CH_W      = 8,
   parameter int unsigned HALF_MAX  = 128
) (
   input  logic [PIX_W-1:0]  norm,
   input  logic [4:0]        code,
   input  logic              alpha_full,
   output logic [4*CH_W-1:0] argb,
   output logic              fmt_err
);
   import pxe_pkg::*;

   if (CH_W != 8) begin : g_bad_ch
      $error("pxe_unpack: only 8-bit channels are supported");
   end
   if (HALF_MAX != 128) begin : g_bad_half
      $error("pxe_unpack: half-range alpha maximum must be 128");
   end

   function automatic logic [7:0] alpha8(input logic [7:0] a, input logic full);
      logic [8:0] dbl;
      if (full) return a;
      if (a > 8'(HALF_MAX)) return 8'hFF;
      dbl = {a, 1'b0} - {8'd0, a[7]};
      return dbl[7:0];
   endfunction

   logic [7:0] ca, cr, cg, cb;

   always_comb begin
      ca      = 8'hFF;
      cr      = 8'h00;
      cg      = 8'h00;
      cb      = 8'h00;
      fmt_err = 1'b0;
      case (code)
         FMT_RGB565: begin
            cr = widen5(norm[15:11]);
            cg = widen6(norm[10:5]);
            cb = widen5(norm[4:0]);
         end
         FMT_RGB888, FMT_XRGB32: begin
            cr = norm[23:16];
            cg = norm[15:8];
            cb = norm[7:0];
         end
         FMT_ARGB8565: begin
            ca = alpha8(norm[23:16], alpha_full);
            cr = widen5(norm[15:11]);
            cg = widen6(norm[10:5]);
            cb = widen5(norm[4:0]);
         end
         FMT_ARGB8888: begin
            ca = alpha8(norm[31:24], alpha_full);
            cr = norm[23:16];
            cg = norm[15:8];
            cb = norm[7:0];
         end
         FMT_ARGB1555: begin
            ca = {8{norm[15]}};
            cr = widen5(norm[14:10]);
            cg = widen5(norm[9:5]);
            cb = widen5(norm[4:0]);
         end
         FMT_ARGB4444: begin
            ca = widen4(norm[15:12]);
            cr = widen4(norm[11:8]);
            cg = widen4(norm[7:4]);
            cb = widen4(norm[3:0]);
         end
         default: fmt_err = 1'b1;
      endcase
      argb = {ca, cr, cg, cb};
   end

   if (PIX_W > 32) begin : g_wide
      logic wide_unused;
      assign wide_unused = ^norm[PIX_W-1:32];
   end

endmodule

// File: rtl/pxe_out_stage.sv
module pxe_out_stage #(
   parameter int unsigned DW = 33
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_valid && in_ready) begin
         out_valid <= 1'b1;
         out_data  <= in_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

   assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

endmodule

// File: rtl/pixel_argb_expander.sv
module pixel_argb_expander #(
   parameter int unsigned PIX_W       = 32,
   parameter int unsigned CTRL_W      = 32,
   parameter int unsigned CH_W        = 8,
   parameter bit          SWAP_EN     = 1'b1,
   parameter bit          ALPHA_LO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_pixel,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic [4*CH_W-1:0] fill_argb,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [4*CH_W-1:0] out_argb,
   output logic              out_fmt_err
);
   import pxe_pkg::*;

   localparam int unsigned ARGB_W = 4 * CH_W;
   localparam int unsigned DW     = ARGB_W + 1;

   if (PIX_W != 32) begin : g_bad_pix
      $error("pixel_argb_expander: PIX_W must be 32");
   end
   if (CTRL_W <= CTL_BIG_END) begin : g_bad_ctrl
      $error("pixel_argb_expander: CTRL_W too narrow for the flag bits");
   end

   logic [4:0]        fmt_code;
   pxe_layout_t       lay;
   logic [PIX_W-1:0]  norm_pix;
   logic [ARGB_W-1:0] dec_argb;
   logic              dec_err;
   logic [ARGB_W-1:0] sel_argb;
   logic              sel_err;
   logic              fill_on;
   logic [DW-1:0]     stage_q;
   logic              ctrl_unused;

   assign fmt_code    = ctrl_word[CTL_FMT_W-1:0];
   assign fill_on     = ctrl_word[CTL_FILL];
   assign lay         = layout_of(fmt_code);
   assign ctrl_unused = ^{ctrl_word[CTRL_W-1:CTL_BIG_END+1],
                          ctrl_word[CTL_BIG_END-1:CTL_FILL+1],
                          ctrl_word[CTL_FILL-1:CTL_ALPHA_LOW+1], lay.known};

   pxe_reorder #(
      .PIX_W      (PIX_W),
      .LANE_W     (8),
      .SWAP_EN    (SWAP_EN),
      .ALPHA_LO_EN(ALPHA_LO_EN)
   ) u_reorder (
      .pix      (in_pixel),
      .nbytes   (lay.nbytes),
      .a_bits   (lay.a_bits),
      .big_end  (ctrl_word[CTL_BIG_END]),
      .alpha_low(ctrl_word[CTL_ALPHA_LOW]),
      .norm     (norm_pix)
   );

   pxe_unpack #(
      .PIX_W   (PIX_W),
      .CH_W    (CH_W),
      .HALF_MAX(128)
   ) u_unpack (
      .norm      (norm_pix),
      .code      (fmt_code),
      .alpha_full(ctrl_word[CTL_ALPHA_FULL]),
      .argb      (dec_argb),
      .fmt_err   (dec_err)
   );

   // Fill overrides decoding and clears the error
   always_comb begin
      if (fill_on) begin
         sel_argb = fill_argb;
         sel_err  = 1'b0;
      end else begin
         sel_argb = dec_argb;
         sel_err  = dec_err;
      end
   end

   pxe_out_stage #(.DW(DW)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  ({sel_err, sel_argb}),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (stage_q)
   );

   assign out_argb    = stage_q[ARGB_W-1:0];
   assign out_fmt_err = stage_q[ARGB_W];

   assert_err_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fmt_err) |-> (out_argb == 32'hFF00_0000));

   assert_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && ctrl_word[CTL_FILL]) |=>
      (out_argb == $past(fill_argb) && !out_fmt_err));

   assert_opaque_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !ctrl_word[CTL_FILL] && ctrl_word[4:2] == 3'b000
       && ctrl_word[1:0] != 2'b11) |=> (out_argb[31:24] == 8'hFF && !out_fmt_err));

endmodule

// File: tb/pixel_argb_expander_tb.sv
`timescale 1ns/1ps
module pixel_argb_expander_tb_top;

   localparam logic [31:0] BE   = 32'h0080_0000;
   localparam logic [31:0] AL   = 32'h0000_0040;
   localparam logic [31:0] AF   = 32'h0000_0020;
   localparam logic [31:0] FILL = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_pixel = '0;
   logic [31:0] ctrl_word = '0;
   logic [31:0] fill_argb = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_argb;
   logic        out_fmt_err;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int acc_cyc = 0;
   bit bp_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   typedef struct {
      logic [31:0] argb;
      logic        err;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   pixel_argb_expander dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_pixel(in_pixel), .ctrl_word(ctrl_word), .fill_argb(fill_argb),
      .out_valid(out_valid), .out_ready(out_ready), .out_argb(out_argb),
      .out_fmt_err(out_fmt_err)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
   end

   task automatic check(input bit ok, input string tag, input logic [32:0] act,
                        input logic [32:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: a word leaves at the next rising edge when valid and ready
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R2 unexpected output", {out_fmt_err, out_argb}, 33'h0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(out_argb === e.argb && out_fmt_err === e.err, e.tag,
                  {out_fmt_err, out_argb}, {e.err, e.argb});
         end
      end
   end

   // Driver: called 1 ns after a rising edge, returns 1 ns after accepting edge
   task automatic send(input logic [31:0] pix, input logic [31:0] ctl,
                       input logic [31:0] fill, input logic [31:0] exp_argb,
                       input logic exp_err, input string tag);
      exp_t e;
      in_valid  = 1'b1;
      in_pixel  = pix;
      ctrl_word = ctl;
      fill_argb = fill;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      e.argb = exp_argb;
      e.err  = exp_err;
      e.tag  = tag;
      sb_q.push_back(e);
      acc_cyc = cyc;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 2000 && sb_q.size() != 0; k++) @(posedge clk);
      #1;
      check(sb_q.size() == 0, "R2 drain", 33'(sb_q.size()), 33'h0);
   endtask

   task automatic run_set(input string sfx);
      // R3 16-bit layouts and widening
      send(32'h0000_F800, 32'h00, 0, 32'hFFFF0000, 1'b0, {"R3 565 red ", sfx});
      send(32'h0000_07E0, 32'h00, 0, 32'hFF00FF00, 1'b0, {"R3 565 green ", sfx});
      send(32'h0000_8410, 32'h00, 0, 32'hFF848284, 1'b0, {"R3 565 mid ", sfx});
      send(32'h0000_8C3A, 32'h07, 0, 32'h88CC33AA, 1'b0, {"R3 4444 ", sfx});
      send(32'h0000_FC1F, 32'h06, 0, 32'hFFFF00FF, 1'b0, {"R8 1555 a1 ", sfx});
      send(32'h0000_7C1F, 32'h06, 0, 32'h00FF00FF, 1'b0, {"R8 1555 a0 ", sfx});
      // R4 wider layouts
      send(32'hAB12_3456, 32'h01, 0, 32'hFF123456, 1'b0, {"R4 888 ", sfx});
      send(32'h77AB_CDEF, 32'h02, 0, 32'hFFABCDEF, 1'b0, {"R4 xrgb ", sfx});
      send(32'h4011_2233, 32'h05 | AF, 0, 32'h40112233, 1'b0, {"R4 8888 ", sfx});
      send(32'h005A_F800, 32'h04 | AF, 0, 32'h5AFF0000, 1'b0, {"R4 8565 ", sfx});
      // R7 alpha scaling
      send(32'h4011_2233, 32'h05, 0, 32'h80112233, 1'b0, {"R7 a40 ", sfx});
      send(32'h8011_2233, 32'h05, 0, 32'hFF112233, 1'b0, {"R7 a80 ", sfx});
      send(32'h9011_2233, 32'h05, 0, 32'hFF112233, 1'b0, {"R7 a90 sat ", sfx});
      send(32'h0111_2233, 32'h05, 0, 32'h02112233, 1'b0, {"R7 a01 ", sfx});
      send(32'h005A_F800, 32'h04, 0, 32'hB4FF0000, 1'b0, {"R7 8565 a5a ", sfx});
      // R5 byte order
      send(32'h0000_00F8, 32'h00 | BE, 0, 32'hFFFF0000, 1'b0, {"R5 565 be ", sfx});
      send(32'hEE56_3412, 32'h01 | BE, 0, 32'hFF123456, 1'b0, {"R5 888 be ", sfx});
      // R6 alpha at low end
      send(32'hAA33_2211, 32'h05 | BE | AL | AF, 0, 32'hAA112233, 1'b0, {"R6 be+low 8888 ", sfx});
      send(32'h1122_3344, 32'h05 | AL | AF, 0, 32'h44112233, 1'b0, {"R6 low 8888 ", sfx});
      send(32'h0000_C3A8, 32'h07 | AL, 0, 32'h88CC33AA, 1'b0, {"R6 low 4444 ", sfx});
      send(32'h0000_F83F, 32'h06 | AL, 0, 32'hFFFF00FF, 1'b0, {"R6 low 1555 ", sfx});
      send(32'h00F8_005A, 32'h04 | AL | AF, 0, 32'h5AFF0000, 1'b0, {"R6 low 8565 ", sfx});
      send(32'h0012_3456, 32'h01 | AL, 0, 32'hFF123456, 1'b0, {"R6 ignored 888 ", sfx});
      // R9 undefined codes
      send(32'h1234_5678, 32'h03, 0, 32'hFF000000, 1'b1, {"R9 code03 ", sfx});
      send(32'h1234_5678, 32'h1F, 0, 32'hFF000000, 1'b1, {"R9 code1f ", sfx});
      send(32'hFFFF_FFFF, 32'h08 | AF, 0, 32'hFF000000, 1'b1, {"R9 code08 ", sfx});
      // R10 fill
      send(32'h1122_3344, 32'h05 | FILL, 32'h1234_5678, 32'h12345678, 1'b0, {"R10 fill ", sfx});
      send(32'h1122_3344, 32'h03 | FILL, 32'hCAFE_0001, 32'hCAFE0001, 1'b0, {"R10 fill bad code ", sfx});
      // R11 unrelated control bits
      send(32'h4011_2233, 32'h8000_0C85 | AF, 0, 32'h40112233, 1'b0, {"R11 other bits ", sfx});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int first_acc;
      repeat (5) @(posedge clk);
      #1;
      check(out_valid === 1'b0, "R1 out_valid in reset", {32'h0, out_valid}, 33'h0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(out_valid === 1'b0, "R1 out_valid after reset", {32'h0, out_valid}, 33'h0);
      check(in_ready === 1'b1, "R2 in_ready idle", {32'h0, in_ready}, 33'h1);

      // R2 single-cycle latency
      send(32'h0000_F800, 32'h00, 0, 32'hFFFF0000, 1'b0, "R2 latency word");
      check(out_valid === 1'b1 && out_argb === 32'hFFFF0000, "R2 latency",
            {out_valid, out_argb}, {1'b1, 32'hFFFF0000});
      drain();

      // R2 full throughput burst
      send(32'h0000_0001, 32'h07, 0, 32'h00000011, 1'b0, "R2 burst 0");
      first_acc = acc_cyc;
      for (int i = 1; i < 6; i++) begin
         send({16'h0, 4'h0, 4'(i), 8'h00}, 32'h07, 0,
              {8'h00, 4'(i), 4'(i), 16'h0000}, 1'b0, "R2 burst n");
      end
      check(acc_cyc - first_acc == 5, "R2 burst spacing", 33'(acc_cyc - first_acc), 33'd5);
      drain();

      run_set("flow");
      drain();

      bp_en = 1'b1;
      run_set("stall");
      drain();
      bp_en = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule